// File: doc/BRIEF.md
# Latched Trip Override for Gate Drive Outputs

This block sits between a PWM generator with dead-band logic and the gate driver pins. In normal operation it passes the two complementary gate signals through unchanged. When a fault is reported on the external trip pin, or when software issues a force strobe, a trip latch sets. While the latch is set, both gate outputs are held low, which is the safe state that switches the power devices off.

The latch is sticky. A trip pin that returns to its idle level does not release it. Only a software clear strobe releases it, and the clear has no effect while a set source is still active in the same cycle. Software normally issues the force strobe during configuration, so that the gates stay off until it deliberately clears the latch. The trip pin is active-low and asynchronous, so it passes through a synchronizer before it can reach the latch.

An interrupt request flag records the moment the latch goes from clear to set, but only if the interrupt enable is high in that cycle. Software lowers the flag with the same clear strobe that releases the latch.

Top module: `trip_guard`

## Requirements
- R1: While reset is held and just after it is released, `tripped` and `irq` are 0 and each gate output equals its gate input.
- R2: While `tripped` is 0, `gate_a_out` equals `gate_a_in` and `gate_b_out` equals `gate_b_in` in the same cycle.
- R3: While `tripped` is 1, `gate_a_out` and `gate_b_out` are both 0, whatever the gate inputs are.
- R4: `trip_n` is active-low. A low level on `trip_n` that is sampled at a rising edge sets `tripped` at the second rising edge after that sampling edge. This gives two synchronizer stages when `SYNC_STAGES` is 2.
- R5: A high `sw_force` at a rising edge sets `tripped` at that edge.
- R6: Once `tripped` is set, it stays set when `trip_n` returns high, and it stays set for as long as `sw_clear` is not asserted.
- R7: A high `sw_clear` at a rising edge clears `tripped` only if neither `sw_force` nor the synchronized trip is active at that edge. If a set source coincides with the clear, the set source wins and `tripped` stays 1.
- R8: `irq` rises only at an edge where `tripped` goes from 0 to 1 while `irq_en` is 1. A set source that arrives while `tripped` is already 1 does not raise `irq`.
- R9: Once raised, `irq` stays at 1 until a `sw_clear` strobe lowers it, and it stays at 1 even if `irq_en` falls.
- R10: If `irq_en` is 0 when the latch sets, `irq` stays 0. Raising `irq_en` afterwards, while the latch is still set, does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_n | input | 1 | External trip pin, active-low, asynchronous |
| sw_force | input | 1 | Software strobe that sets the trip latch |
| sw_clear | input | 1 | Software strobe that clears the trip latch and the interrupt flag |
| irq_en | input | 1 | Interrupt enable |
| gate_a_in | input | 1 | Gate signal A from the dead-band stage |
| gate_b_in | input | 1 | Gate signal B from the dead-band stage |
| gate_a_out | output | 1 | Gate signal A after the override |
| gate_b_out | output | 1 | Gate signal B after the override |
| tripped | output | 1 | Trip latch state |
| irq | output | 1 | Interrupt request flag |

## Verification
The two functions that can fall in the same cycle are setting the latch and clearing it. A clear strobe can coincide with a force strobe, or with a trip pin level that is still low after it has passed through the synchronizer.

The bench provokes these cases in two ways:
- It holds `trip_n` low while it pulses `sw_clear`.
- It issues `sw_force` and `sw_clear` together.

A behavioural reference model decides, on every clock, that the latch stays set in these cases. The same collisions also decide whether `irq` may rise. Random runs that use sparse strobes produce further overlaps of this kind, which are compared cycle by cycle.

// File: rtl/trip_guard.sv
module trip_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_n,
  input  logic sw_force,
  input  logic sw_clear,
  input  logic irq_en,
  input  logic gate_a_in,
  input  logic gate_b_in,
  output logic gate_a_out,
  output logic gate_b_out,
  output logic tripped,
  output logic irq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          trip_seen;
  logic          set_req;
  logic          rise;
  logic          latch_q;
  logic          irq_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= trip_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[LAST-1:0], trip_n};
      end
    end
  endgenerate

  assign trip_seen = ~sync_q[LAST];
  assign set_req   = trip_seen | sw_force;
  assign rise      = set_req & ~latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (set_req)       latch_q <= 1'b1;
      else if (sw_clear) latch_q <= 1'b0;

      if (rise && irq_en) irq_q <= 1'b1;
      else if (sw_clear)  irq_q <= 1'b0;
    end
  end

  assign gate_a_out = gate_a_in & ~latch_q;
  assign gate_b_out = gate_b_in & ~latch_q;
  assign tripped    = latch_q;
  assign irq        = irq_q;

endmodule

// File: rtl/trip_guard_chk.sv
module trip_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_force,
  input logic sw_clear,
  input logic irq_en,
  input logic trip_seen,
  input logic gate_a_in,
  input logic gate_b_in,
  input logic gate_a_out,
  input logic gate_b_out,
  input logic tripped,
  input logic irq
);

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    !tripped |-> (gate_a_out == gate_a_in) && (gate_b_out == gate_b_in));

  a_r3_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> !gate_a_out && !gate_b_out);

  a_r4_pin_sets: assert property (@(posedge clk) disable iff (!rst_n)
    trip_seen |=> tripped);

  a_r5_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sw_force |=> tripped);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tripped && !sw_clear |=> tripped);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear && !sw_force && !trip_seen |=> !tripped);

  a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $rose(tripped) && $past(irq_en));

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !sw_clear |=> irq);

endmodule

bind trip_guard trip_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_force(sw_force), .sw_clear(sw_clear),
  .irq_en(irq_en), .trip_seen(trip_seen), .gate_a_in(gate_a_in),
  .gate_b_in(gate_b_in), .gate_a_out(gate_a_out), .gate_b_out(gate_b_out),
  .tripped(tripped), .irq(irq)
);

// File: tb/sim_trip_guard.sv
`timescale 1ns/1ps
module sim_trip_guard;

  localparam int SYNC_STAGES = 2;
  localparam int WATCHDOG    = 100000;

  logic clk = 1'b0;
  logic rst_n, trip_n, sw_force, sw_clear, irq_en, ga, gb;
  logic gao, gbo, tripped, irq;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  bit syncq[$];
  bit m_lat, m_irq;

  always #2 clk = ~clk;

  trip_guard #(.SYNC_STAGES(SYNC_STAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .sw_force(sw_force),
    .sw_clear(sw_clear), .irq_en(irq_en), .gate_a_in(ga), .gate_b_in(gb),
    .gate_a_out(gao), .gate_b_out(gbo), .tripped(tripped), .irq(irq)
  );

  task automatic compare(string tag);
    bit ea, eb;
    ea = ga & ~m_lat;
    eb = gb & ~m_lat;
    vectors++;
    if (gao !== ea || gbo !== eb || tripped !== m_lat || irq !== m_irq) begin
      miscompares++;
      $display("FAIL %s: got a=%b b=%b tripped=%b irq=%b, expected a=%b b=%b tripped=%b irq=%b",
               tag, gao, gbo, tripped, irq, ea, eb, m_lat, m_irq);
    end
  endtask

  task automatic model_reset();
    syncq.delete();
    for (int i = 0; i < SYNC_STAGES; i++) syncq.push_back(1'b1);
    m_lat = 1'b0;
    m_irq = 1'b0;
  endtask

  task automatic cyc(string tag, bit tn, bit f, bit c, bit en, bit a, bit b);
    bit set, rise, nl, ni;
    @(negedge clk);
    trip_n = tn; sw_force = f; sw_clear = c; irq_en = en; ga = a; gb = b;
    #0.5;
    compare(tag);
    set  = f | ~syncq[SYNC_STAGES-1];
    rise = set & ~m_lat;
    nl   = set ? 1'b1 : (c ? 1'b0 : m_lat);
    ni   = (rise & en) ? 1'b1 : (c ? 1'b0 : m_irq);
    @(posedge clk);
    cycles++;
    syncq.push_front(tn);
    void'(syncq.pop_back());
    m_lat = nl;
    m_irq = ni;
    #1;
    compare(tag);
  endtask

  initial begin
    #(WATCHDOG * 4);
    miscompares++;
    $display("FAIL watchdog: got no end after %0d cycles, expected completion", WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trip_n = 1'b1; sw_force = 1'b0; sw_clear = 1'b0;
    irq_en = 1'b0; ga = 1'b1; gb = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1 after reset", 1, 0, 0, 0, 1, 1);

    for (int i = 0; i < 16; i++)
      cyc("R2 pass", 1, 0, 0, 0, i[0], i[1]);

    cyc("R4 pin low", 0, 0, 0, 0, 1, 0);
    cyc("R4 pin low", 0, 0, 0, 0, 0, 1);
    cyc("R4 pin low", 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 10; i++)
      cyc("R6 sticky, R3 forced", 1, 0, 0, 0, i[0], ~i[0]);
    cyc("R7 clear", 1, 0, 1, 0, 1, 1);
    cyc("R2 pass after clear", 1, 0, 0, 0, 1, 1);

    cyc("R5 force", 1, 1, 0, 0, 1, 1);
    cyc("R3 forced", 1, 0, 0, 0, 1, 1);
    cyc("R7 force with clear", 1, 1, 1, 0, 1, 1);
    cyc("R7 clear", 1, 0, 1, 0, 1, 1);

    cyc("R7 pin low", 0, 0, 0, 0, 1, 1);
    cyc("R7 pin low with clear", 0, 0, 1, 0, 1, 1);
    cyc("R7 pin low with clear", 0, 0, 1, 0, 1, 1);
    cyc("R7 pin low with clear", 0, 0, 1, 0, 1, 1);
    cyc("R7 pin high, clear in pipe", 1, 0, 1, 0, 1, 1);
    cyc("R7 pin high, clear in pipe", 1, 0, 1, 0, 1, 1);
    cyc("R7 clear effective", 1, 0, 1, 0, 1, 1);
    cyc("R2 pass", 1, 0, 0, 0, 1, 0);

    cyc("R8 irq on force", 1, 1, 0, 1, 1, 1);
    cyc("R8 no re-raise", 1, 1, 0, 1, 1, 1);
    cyc("R9 irq holds, enable low", 1, 0, 0, 0, 1, 1);
    cyc("R9 irq holds", 1, 0, 0, 0, 0, 1);
    cyc("R9 clear lowers irq", 1, 0, 1, 1, 1, 1);
    cyc("R8 retrip by pin", 0, 0, 0, 1, 1, 1);
    cyc("R8 retrip by pin", 0, 0, 0, 1, 1, 1);
    cyc("R8 irq from pin", 1, 0, 0, 1, 1, 1);
    cyc("R8 clear", 1, 0, 1, 0, 1, 1);

    cyc("R10 force, irq disabled", 1, 1, 0, 0, 1, 1);
    cyc("R10 enable later", 1, 0, 0, 1, 1, 1);
    cyc("R10 enable later", 1, 1, 0, 1, 1, 1);
    cyc("R10 clear", 1, 0, 1, 1, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      bit tn, f, c, en;
      tn = ($urandom_range(0, 15) != 0);
      f  = ($urandom_range(0, 31) == 0);
      c  = ($urandom_range(0, 7) == 0);
      en = ($urandom_range(0, 3) != 0);
      cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 random", tn, f, c, en,
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(posedge clk);
    #1 compare("R1 mid-run reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule